// File: doc/BRIEF.md
# Parallel Flash Query Probe Decoder

This block runs once after reset on a parallel NOR flash bus and learns what kind of device sits there. It does not know the bus width in advance, so it tries byte, half-word and word widths in turn. At each width it puts the device into query mode and looks for the identification string. Once it has locked onto a width, every later query offset is scaled by that width. The block then reads the command-set identifier, the device size, the interface capability word, the three pairs of operation-timeout exponents and up to `MAX_REG` erase-region descriptors.

Each query byte is read with its own three bus operations: query-entry write, read, and return-to-array write. The decoded values are applied to the timeout exponents, which get their defaults and are checked against sanity limits, and to the region fields. The results land in read-only registers that a neighbouring block reads through a combinational index port.

A single `probe_done` pulse marks the end of the run, and `probe_err` with a code in the status register tells whether the device was accepted. The run stops at the first failed check.

Top module: `flash_query_probe`

## Requirements
- R1: Widths are tried in the order 1, 2, 4 bytes. The first width whose identification read (offset 0x10) returns 0x51 is adopted, no larger width is tried, and the adopted width appears in bits [2:0] of register 0.
- R2: Each query byte takes three bus operations. First a write of 0x98 to address 0x55 times the width. Then a read at the offset times the width, whose data returns on `fl_rdata` in the cycle after the read strobe, with the byte in bits [7:0]. Then a write of 0xFF to address 0. No other bus operation occurs.
- R3: If no width yields 0x51, the block stops with error code 1 in bits [6:4] of register 0, and bits [2:0] read 0.
- R4: After the identifier, offsets 0x11 and 0x12 must read 0x52 and 0x59. Otherwise the block stops with error code 2, and no later offset is read.
- R5: The command-set word (offsets 0x13, 0x14) and the interface word (offsets 0x28, 0x29) are assembled low byte first and shown in registers 1 and 3, bits [15:0].
- R6: Register 2 holds 1 shifted left by the size byte (offset 0x27), or 0 when that byte is 32 or more.
- R7: If the interface word plus one (16-bit wrap), ANDed with the width, is zero, the block stops with error code 3.
- R8: The erase typical exponent (offset 0x21) defaults to 16 when 0, and the erase multiplier (offset 0x25) defaults to 4 when 0. Both are shown in register 4 bits [7:0] and [15:8]. If the typical value exceeds 41, or the sum exceeds 41, the block stops with error code 4 after reading both.
- R9: The write typical exponent (offset 0x1F) defaults to 18 when 0, and the write multiplier (offset 0x23) defaults to 4 when 0. They are shown in register 4 bits [23:16] and [31:24], with limit 51 and error code 5. The buffered-write pair (offsets 0x20, 0x24) is stored raw, with no default, in register 5 bits [7:0] and [15:8].
- R10: Register 6 holds the raw region count (offset 0x2C). Only the first min(count, MAX_REG) regions are read, at offsets 0x2D+4r to 0x30+4r. Register 8+2r holds the 16-bit block field plus 1. Register 9+2r holds the size field times 256, or 128 when the field is 0. Undecoded regions and unused indices read 0.
- R11: `probe_busy` is high from reset release until completion. `probe_done` pulses for exactly one cycle, after which the bus stays idle and all results hold. `probe_err` is high when the error code is non-zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| fl_rdata | input | DATA_W | Flash read data, valid the cycle after `fl_re` |
| fl_we | output | 1 | Flash write strobe |
| fl_re | output | 1 | Flash read strobe |
| fl_addr | output | ADDR_W | Flash byte address |
| fl_wdata | output | DATA_W | Flash write data (command byte in [7:0]) |
| reg_sel | input | REG_SEL_W | Result register index |
| reg_rdata | output | 32 | Selected result register |
| probe_busy | output | 1 | Probe in progress |
| probe_done | output | 1 | One-cycle completion pulse |
| probe_err | output | 1 | Device rejected or not found |

## Verification
The bench goes after the width scan with devices answering at each width and at none. A decoder that scaled the query-entry address wrongly, or kept scanning after a hit, would emit an unexpected bus operation. Sanity limits are hit exactly at and one past the boundary (sum 41 accepted, 42 rejected; 51 accepted, 52 rejected), where an off-by-one comparator would flip the error code. A region count above the register capacity and a count of zero check the region loop bounds, and a size byte of 40 checks the oversize rule. Early-abort cases (bad signature, bad interface) check that the block stops reading at once rather than reading on and overwriting later registers.

// File: rtl/fqp_pkg.sv
package fqp_pkg;
  // Query protocol constants; offsets are fixed by the flash devices
  localparam logic [7:0] CMD_QUERY = 8'h98;
  localparam logic [7:0] CMD_ARRAY = 8'hFF;
  localparam logic [7:0] OFS_QCMD  = 8'h55;
  localparam logic [7:0] OFS_IDENT = 8'h10;
  localparam logic [7:0] OFS_VEND  = 8'h13;
  localparam logic [7:0] OFS_WTT   = 8'h1F;
  localparam logic [7:0] OFS_BTT   = 8'h20;
  localparam logic [7:0] OFS_ETT   = 8'h21;
  localparam logic [7:0] OFS_WMT   = 8'h23;
  localparam logic [7:0] OFS_BMT   = 8'h24;
  localparam logic [7:0] OFS_EMT   = 8'h25;
  localparam logic [7:0] OFS_SIZE  = 8'h27;
  localparam logic [7:0] OFS_IFACE = 8'h28;
  localparam logic [7:0] OFS_NREG  = 8'h2C;
  localparam logic [7:0] OFS_REG0  = 8'h2D;
  localparam logic [7:0] CH_Q = 8'h51;
  localparam logic [7:0] CH_R = 8'h52;
  localparam logic [7:0] CH_Y = 8'h59;
  localparam logic [8:0] ERASE_LIM = 9'd41;
  localparam logic [8:0] WRITE_LIM = 9'd51;
  localparam logic [7:0] ERASE_TT_DEF = 8'd16;
  localparam logic [7:0] ERASE_MT_DEF = 8'd4;
  localparam logic [7:0] WRITE_TT_DEF = 8'd18;
  localparam logic [7:0] WRITE_MT_DEF = 8'd4;

  typedef enum logic [2:0] {
    E_NONE = 3'd0, E_ABSENT = 3'd1, E_SIGNATURE = 3'd2,
    E_IFACE = 3'd3, E_ERASE_TO = 3'd4, E_WRITE_TO = 3'd5
  } err_e;

  typedef enum logic [4:0] {
    ST_SCAN, ST_SIG_R, ST_SIG_Y, ST_VEN_LO, ST_VEN_HI, ST_SIZE,
    ST_IF_LO, ST_IF_HI, ST_ETT, ST_EMT, ST_WTT, ST_WMT, ST_BTT,
    ST_BMT, ST_NREG, ST_REGION, ST_FINISH, ST_HALT
  } step_e;
endpackage

// File: rtl/fqp_bus_engine.sv
module fqp_bus_engine import fqp_pkg::*; #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic [7:0]        ofs,
  input  logic [2:0]        width,
  input  logic [DATA_W-1:0] fl_rdata,
  output logic              fl_we,
  output logic              fl_re,
  output logic [ADDR_W-1:0] fl_addr,
  output logic [DATA_W-1:0] fl_wdata,
  output logic              ack,
  output logic [7:0]        qbyte
);
  typedef enum logic [2:0] {B_IDLE, B_CMD, B_RD, B_WAIT, B_ARR} bst_e;
  bst_e       st_q, st_d;
  logic [7:0] byte_q, byte_d;
  logic [ADDR_W-1:0] w_ext;

  assign w_ext = ADDR_W'(width);
  assign qbyte = byte_q;

  always_comb begin
    st_d     = st_q;
    byte_d   = byte_q;
    fl_we    = 1'b0;
    fl_re    = 1'b0;
    fl_addr  = '0;
    fl_wdata = '0;
    ack      = 1'b0;
    case (st_q)
      B_IDLE: if (req) st_d = B_CMD;
      B_CMD: begin
        fl_we    = 1'b1;
        fl_addr  = ADDR_W'(OFS_QCMD) * w_ext;
        fl_wdata = DATA_W'(CMD_QUERY);
        st_d     = B_RD;
      end
      B_RD: begin
        fl_re   = 1'b1;
        fl_addr = ADDR_W'(ofs) * w_ext;
        st_d    = B_WAIT;
      end
      B_WAIT: begin
        byte_d = fl_rdata[7:0];
        st_d   = B_ARR;
      end
      B_ARR: begin
        fl_we    = 1'b1;
        fl_wdata = DATA_W'(CMD_ARRAY);
        ack      = 1'b1;
        st_d     = B_IDLE;
      end
      default: st_d = B_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= B_IDLE;
      byte_q <= '0;
    end else begin
      st_q   <= st_d;
      byte_q <= byte_d;
    end
  end

  // R2
  rd_after_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fl_re |-> $past(fl_we));
  // R2
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(fl_we && fl_re));
endmodule

// File: rtl/fqp_region_store.sv
module fqp_region_store #(
  parameter int MAX_REG = 4,
  parameter int RIDX_W  = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [RIDX_W-1:0]       wr_idx,
  input  logic [31:0]             blocks_in,
  input  logic [31:0]             blksz_in,
  output logic [MAX_REG-1:0][31:0] blocks_o,
  output logic [MAX_REG-1:0][31:0] blksz_o
);
  for (genvar g = 0; g < MAX_REG; g++) begin : g_entry
    logic hit;
    assign hit = wr_en && (wr_idx == RIDX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        blocks_o[g] <= '0;
        blksz_o[g]  <= '0;
      end else if (hit) begin
        blocks_o[g] <= blocks_in;
        blksz_o[g]  <= blksz_in;
      end
    end
  end
endmodule

// File: rtl/flash_query_probe.sv
module flash_query_probe import fqp_pkg::*; #(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 32,
  parameter int MAX_REG = 4,
  localparam int RIDX_W    = (MAX_REG > 1) ? $clog2(MAX_REG) : 1,
  localparam int REG_SEL_W = $clog2(8 + 2 * MAX_REG)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [DATA_W-1:0]    fl_rdata,
  output logic                 fl_we,
  output logic                 fl_re,
  output logic [ADDR_W-1:0]    fl_addr,
  output logic [DATA_W-1:0]    fl_wdata,
  input  logic [REG_SEL_W-1:0] reg_sel,
  output logic [31:0]          reg_rdata,
  output logic                 probe_busy,
  output logic                 probe_done,
  output logic                 probe_err
);
  logic [1:0] rs_q;
  logic       srst_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign srst_n = rs_q[1];

  step_e step_q, step_d;
  err_e  err_q, err_d;
  logic [2:0]  width_q, width_d, detw_q, detw_d;
  logic [15:0] vend_q, vend_d, iface_q, iface_d, rblk_q, rblk_d;
  logic [31:0] size_q, size_d;
  logic [7:0]  ett_q, ett_d, emt_q, emt_d, wtt_q, wtt_d, wmt_q, wmt_d;
  logic [7:0]  btt_q, btt_d, bmt_q, bmt_d, nreg_q, nreg_d, lo_q, lo_d;
  logic [RIDX_W-1:0] ridx_q, ridx_d;
  logic [1:0]  sub_q, sub_d;
  logic [7:0]  ofs, qbyte, mt_eff;
  logic        req, ack, rg_we, last_reg;
  logic [15:0] word;
  logic [MAX_REG-1:0][31:0] blocks, blksz;

  assign probe_busy = srst_n && (step_q != ST_FINISH) && (step_q != ST_HALT);
  assign probe_done = (step_q == ST_FINISH);
  assign probe_err  = (err_q != E_NONE);
  assign req        = probe_busy;
  assign word       = {qbyte, lo_q};
  assign last_reg   = (ridx_q == RIDX_W'(MAX_REG - 1)) || ((8'(ridx_q) + 8'd1) >= nreg_q);

  always_comb begin
    case (step_q)
      ST_SIG_R:  ofs = OFS_IDENT + 8'd1;
      ST_SIG_Y:  ofs = OFS_IDENT + 8'd2;
      ST_VEN_LO: ofs = OFS_VEND;
      ST_VEN_HI: ofs = OFS_VEND + 8'd1;
      ST_SIZE:   ofs = OFS_SIZE;
      ST_IF_LO:  ofs = OFS_IFACE;
      ST_IF_HI:  ofs = OFS_IFACE + 8'd1;
      ST_ETT:    ofs = OFS_ETT;
      ST_EMT:    ofs = OFS_EMT;
      ST_WTT:    ofs = OFS_WTT;
      ST_WMT:    ofs = OFS_WMT;
      ST_BTT:    ofs = OFS_BTT;
      ST_BMT:    ofs = OFS_BMT;
      ST_NREG:   ofs = OFS_NREG;
      ST_REGION: ofs = OFS_REG0 + 8'({ridx_q, sub_q});
      default:   ofs = OFS_IDENT;
    endcase
  end

  fqp_bus_engine #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bus (
    .clk(clk), .rst_n(srst_n), .req(req), .ofs(ofs), .width(width_q),
    .fl_rdata(fl_rdata), .fl_we(fl_we), .fl_re(fl_re), .fl_addr(fl_addr),
    .fl_wdata(fl_wdata), .ack(ack), .qbyte(qbyte));

  always_comb begin
    step_d = step_q;  err_d = err_q;    width_d = width_q; detw_d = detw_q;
    vend_d = vend_q;  iface_d = iface_q; rblk_d = rblk_q;  size_d = size_q;
    ett_d = ett_q;    emt_d = emt_q;    wtt_d = wtt_q;     wmt_d = wmt_q;
    btt_d = btt_q;    bmt_d = bmt_q;    nreg_d = nreg_q;   lo_d = lo_q;
    ridx_d = ridx_q;  sub_d = sub_q;    rg_we = 1'b0;      mt_eff = qbyte;
    if (step_q == ST_FINISH) step_d = ST_HALT;
    else if (ack) begin
      case (step_q)
        ST_SCAN: begin
          if (qbyte == CH_Q) begin
            detw_d = width_q;
            step_d = ST_SIG_R;
          end else if (width_q == 3'd4) begin
            err_d  = E_ABSENT;
            step_d = ST_FINISH;
          end else width_d = width_q << 1;
        end
        ST_SIG_R: begin
          if (qbyte != CH_R) begin err_d = E_SIGNATURE; step_d = ST_FINISH; end
          else step_d = ST_SIG_Y;
        end
        ST_SIG_Y: begin
          if (qbyte != CH_Y) begin err_d = E_SIGNATURE; step_d = ST_FINISH; end
          else step_d = ST_VEN_LO;
        end
        ST_VEN_LO: begin lo_d = qbyte; step_d = ST_VEN_HI; end
        ST_VEN_HI: begin vend_d = word; step_d = ST_SIZE; end
        ST_SIZE: begin
          size_d = (qbyte < 8'd32) ? (32'd1 << qbyte[4:0]) : 32'd0;
          step_d = ST_IF_LO;
        end
        ST_IF_LO: begin lo_d = qbyte; step_d = ST_IF_HI; end
        ST_IF_HI: begin
          iface_d = word;
          if (((word + 16'd1) & {13'd0, width_q}) == 16'd0) begin
            err_d = E_IFACE; step_d = ST_FINISH;
          end else step_d = ST_ETT;
        end
        ST_ETT: begin
          ett_d  = (qbyte == 8'd0) ? ERASE_TT_DEF : qbyte;
          step_d = ST_EMT;
        end
        ST_EMT: begin
          mt_eff = (qbyte == 8'd0) ? ERASE_MT_DEF : qbyte;
          emt_d  = mt_eff;
          if ((9'(ett_q) > ERASE_LIM) || ((9'(ett_q) + 9'(mt_eff)) > ERASE_LIM)) begin
            err_d = E_ERASE_TO; step_d = ST_FINISH;
          end else step_d = ST_WTT;
        end
        ST_WTT: begin
          wtt_d  = (qbyte == 8'd0) ? WRITE_TT_DEF : qbyte;
          step_d = ST_WMT;
        end
        ST_WMT: begin
          mt_eff = (qbyte == 8'd0) ? WRITE_MT_DEF : qbyte;
          wmt_d  = mt_eff;
          if ((9'(wtt_q) > WRITE_LIM) || ((9'(wtt_q) + 9'(mt_eff)) > WRITE_LIM)) begin
            err_d = E_WRITE_TO; step_d = ST_FINISH;
          end else step_d = ST_BTT;
        end
        ST_BTT: begin btt_d = qbyte; step_d = ST_BMT; end
        ST_BMT: begin bmt_d = qbyte; step_d = ST_NREG; end
        ST_NREG: begin
          nreg_d = qbyte;
          ridx_d = '0;
          sub_d  = 2'd0;
          step_d = (qbyte == 8'd0) ? ST_FINISH : ST_REGION;
        end
        ST_REGION: begin
          sub_d = sub_q + 2'd1;
          case (sub_q)
            2'd1:    rblk_d = word;
            2'd3: begin
              rg_we = 1'b1;
              if (last_reg) step_d = ST_FINISH;
              else ridx_d = ridx_q + RIDX_W'(1);
            end
            default: lo_d = qbyte;
          endcase
        end
        default: step_d = ST_HALT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      step_q <= ST_SCAN; err_q <= E_NONE; width_q <= 3'd1; detw_q <= '0;
      vend_q <= '0; iface_q <= '0; rblk_q <= '0; size_q <= '0;
      ett_q <= '0; emt_q <= '0; wtt_q <= '0; wmt_q <= '0;
      btt_q <= '0; bmt_q <= '0; nreg_q <= '0; lo_q <= '0;
      ridx_q <= '0; sub_q <= '0;
    end else begin
      step_q <= step_d; err_q <= err_d; width_q <= width_d; detw_q <= detw_d;
      vend_q <= vend_d; iface_q <= iface_d; rblk_q <= rblk_d; size_q <= size_d;
      ett_q <= ett_d; emt_q <= emt_d; wtt_q <= wtt_d; wmt_q <= wmt_d;
      btt_q <= btt_d; bmt_q <= bmt_d; nreg_q <= nreg_d; lo_q <= lo_d;
      ridx_q <= ridx_d; sub_q <= sub_d;
    end
  end

  fqp_region_store #(.MAX_REG(MAX_REG), .RIDX_W(RIDX_W)) u_regions (
    .clk(clk), .rst_n(srst_n), .wr_en(rg_we), .wr_idx(ridx_q),
    .blocks_in(32'(rblk_q) + 32'd1),
    .blksz_in((word == 16'd0) ? 32'd128 : (32'(word) << 8)),
    .blocks_o(blocks), .blksz_o(blksz));

  always_comb begin
    reg_rdata = '0;
    case (reg_sel)
      REG_SEL_W'(0): reg_rdata = {25'd0, err_q, 1'b0, detw_q};
      REG_SEL_W'(1): reg_rdata = {16'd0, vend_q};
      REG_SEL_W'(2): reg_rdata = size_q;
      REG_SEL_W'(3): reg_rdata = {16'd0, iface_q};
      REG_SEL_W'(4): reg_rdata = {wmt_q, wtt_q, emt_q, ett_q};
      REG_SEL_W'(5): reg_rdata = {16'd0, bmt_q, btt_q};
      REG_SEL_W'(6): reg_rdata = {24'd0, nreg_q};
      default: begin
        for (int r = 0; r < MAX_REG; r++) begin
          if (reg_sel == REG_SEL_W'(8 + 2 * r)) reg_rdata = blocks[r];
          if (reg_sel == REG_SEL_W'(9 + 2 * r)) reg_rdata = blksz[r];
        end
      end
    endcase
  end

  // R1
  width_doubles_chk: assert property (@(posedge clk) disable iff (!srst_n)
    !$stable(width_q) |-> (width_q == ($past(width_q) << 1)));
  // R1
  detw_onehot_chk: assert property (@(posedge clk) disable iff (!srst_n)
    $onehot0(detw_q));
  // R3
  absent_nowidth_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (err_q == E_ABSENT) |-> (detw_q == 3'd0));
  // R8
  erase_limit_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (step_q == ST_WTT) |-> ((9'(ett_q) <= ERASE_LIM) && ((9'(ett_q) + 9'(emt_q)) <= ERASE_LIM)));
  // R9
  write_limit_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (step_q == ST_BTT) |-> ((9'(wtt_q) <= WRITE_LIM) && ((9'(wtt_q) + 9'(wmt_q)) <= WRITE_LIM)));
  // R11
  done_single_chk: assert property (@(posedge clk) disable iff (!srst_n)
    probe_done |=> (!probe_done && !probe_busy));
  // R11
  quiet_after_chk: assert property (@(posedge clk) disable iff (!srst_n)
    !probe_busy |-> (!fl_we && !fl_re));
  // R11
  result_hold_chk: assert property (@(posedge clk) disable iff (!srst_n)
    !probe_busy |=> ($stable(err_q) && $stable(detw_q)));
endmodule

// File: tb/flash_query_probe_tb.sv
`timescale 1ns/1ps
module flash_query_probe_tb;
  localparam int AW = 16;
  localparam int DW = 32;
  localparam int NR = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic          fl_we, fl_re;
  logic [AW-1:0] fl_addr;
  logic [DW-1:0] fl_wdata;
  logic [DW-1:0] fl_rdata;
  logic [3:0]    reg_sel = '0;
  logic [31:0]   reg_rdata;
  logic          probe_busy, probe_done, probe_err;

  flash_query_probe #(.ADDR_W(AW), .DATA_W(DW), .MAX_REG(NR)) u_dut (
    .clk(clk), .rst_n(rst_n), .fl_rdata(fl_rdata), .fl_we(fl_we), .fl_re(fl_re),
    .fl_addr(fl_addr), .fl_wdata(fl_wdata), .reg_sel(reg_sel), .reg_rdata(reg_rdata),
    .probe_busy(probe_busy), .probe_done(probe_done), .probe_err(probe_err));

  // Behavioural flash: native width dev_w, query table qtab
  logic [7:0] qtab [64];
  int   dev_w = 2;
  logic qmode;
  always @(posedge clk) begin
    if (!rst_n) qmode <= 1'b0;
    else begin
      if (fl_we && fl_wdata[7:0] == 8'h98 && int'(fl_addr) == 85 * dev_w) qmode <= 1'b1;
      else if (fl_we && fl_wdata[7:0] == 8'hFF) qmode <= 1'b0;
      if (fl_re)
        fl_rdata <= (qmode && (int'(fl_addr) % dev_w == 0) && (int'(fl_addr) / dev_w < 64))
                    ? {24'h0, qtab[int'(fl_addr) / dev_w]} : '1;
    end
  end

  // Reference model state
  int ex_k[$], ex_a[$], ex_d[$];
  int tests = 0, fails = 0, done_cnt = 0;
  int mk, ma, md;
  int e_err, e_width, e_vend, e_size, e_if, et, em, wt, wm, bt, bm, e_nreg;
  int e_blk[NR], e_bsz[NR];

  always @(negedge clk) begin
    if (rst_n) begin
      if (probe_done) done_cnt++;
      if (fl_we || fl_re) begin
        tests++;
        if (ex_k.size() == 0) begin
          fails++;
          $display("FAIL R11 unexpected bus op: actual addr=%0h we=%0b expected none", fl_addr, fl_we);
        end else begin
          mk = ex_k.pop_front(); ma = ex_a.pop_front(); md = ex_d.pop_front();
          if (mk != (fl_we ? 1 : 2) || ma != int'(fl_addr) || (fl_we && md != int'(fl_wdata))) begin
            fails++;
            $display("FAIL R2 bus op: actual we=%0b addr=%0h data=%0h expected kind=%0d addr=%0h data=%0h",
                     fl_we, fl_addr, fl_wdata, mk, ma, md);
          end
        end
      end
    end
  end

  task automatic chk(string tag, string what, logic [31:0] got, logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, got, exp);
    end
  endtask

  task automatic rd(input int idx, output logic [31:0] v);
    @(negedge clk);
    reg_sel = 4'(idx);
    #1 v = reg_rdata;
  endtask

  task automatic push_acc(int w, int ofs);
    ex_k.push_back(1); ex_a.push_back(85 * w);  ex_d.push_back(32'h98);
    ex_k.push_back(2); ex_a.push_back(ofs * w); ex_d.push_back(0);
    ex_k.push_back(1); ex_a.push_back(0);       ex_d.push_back(32'hFF);
  endtask

  function automatic int qb(int o);
    return int'(qtab[o]);
  endfunction

  task automatic build_model(int d);
    int w = 0;
    int n, f;
    e_err = 0; e_width = 0; e_vend = 0; e_size = 0; e_if = 0;
    et = 0; em = 0; wt = 0; wm = 0; bt = 0; bm = 0; e_nreg = 0;
    for (int r = 0; r < NR; r++) begin e_blk[r] = 0; e_bsz[r] = 0; end
    for (int t = 1; t <= 4; t = t * 2) begin
      push_acc(t, 16);
      if (t == d && qb(16) == 8'h51) begin w = t; break; end
    end
    if (w == 0) begin e_err = 1; return; end
    e_width = w;
    push_acc(w, 17); if (qb(17) != 8'h52) begin e_err = 2; return; end
    push_acc(w, 18); if (qb(18) != 8'h59) begin e_err = 2; return; end
    push_acc(w, 19); push_acc(w, 20); e_vend = qb(19) | (qb(20) << 8);
    push_acc(w, 39); e_size = (qb(39) < 32) ? (1 << qb(39)) : 0;
    push_acc(w, 40); push_acc(w, 41); e_if = qb(40) | (qb(41) << 8);
    if ((((e_if + 1) & 16'hFFFF) & w) == 0) begin e_err = 3; return; end
    push_acc(w, 8'h21); push_acc(w, 8'h25);
    et = (qb(8'h21) == 0) ? 16 : qb(8'h21);
    em = (qb(8'h25) == 0) ? 4 : qb(8'h25);
    if (et > 41 || et + em > 41) begin e_err = 4; return; end
    push_acc(w, 8'h1F); push_acc(w, 8'h23);
    wt = (qb(8'h1F) == 0) ? 18 : qb(8'h1F);
    wm = (qb(8'h23) == 0) ? 4 : qb(8'h23);
    if (wt > 51 || wt + wm > 51) begin e_err = 5; return; end
    push_acc(w, 8'h20); push_acc(w, 8'h24);
    bt = qb(8'h20); bm = qb(8'h24);
    push_acc(w, 8'h2C); e_nreg = qb(8'h2C);
    n = (e_nreg < NR) ? e_nreg : NR;
    for (int r = 0; r < n; r++) begin
      for (int s = 0; s < 4; s++) push_acc(w, 8'h2D + 4 * r + s);
      e_blk[r] = (qb(8'h2D + 4 * r) | (qb(8'h2E + 4 * r) << 8)) + 1;
      f = qb(8'h2F + 4 * r) | (qb(8'h30 + 4 * r) << 8);
      e_bsz[r] = (f == 0) ? 128 : f * 256;
    end
  endtask

  task automatic base_table();
    for (int i = 0; i < 64; i++) qtab[i] = 8'h00;
    qtab[16] = 8'h51; qtab[17] = 8'h52; qtab[18] = 8'h59;
    qtab[19] = 8'h02; qtab[39] = 8'h17; qtab[40] = 8'h01;
    qtab[8'h20] = 8'h05; qtab[8'h24] = 8'h03; qtab[8'h2C] = 8'h02;
    qtab[8'h2D] = 8'h03; qtab[8'h2F] = 8'h20;
    qtab[8'h31] = 8'h7E;
  endtask

  task automatic run_case(string name, int d, string stag);
    logic [31:0] v;
    int cyc;
    rst_n = 1'b0;
    dev_w = d;
    ex_k.delete(); ex_a.delete(); ex_d.delete();
    repeat (3) @(negedge clk);
    done_cnt = 0;
    build_model(d);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R11", {name, " busy while probing"}, 32'(probe_busy), 32'd1);
    cyc = 0;
    while (!probe_done && cyc < 5000) begin @(negedge clk); cyc++; end
    if (cyc >= 5000) begin
      tests++; fails++;
      $display("FAIL R11 %s watchdog: actual no done expected done", name);
    end
    repeat (20) @(negedge clk);
    chk("R11", {name, " done pulses"}, 32'(done_cnt), 32'd1);
    chk("R11", {name, " busy after done"}, 32'(probe_busy), 32'd0);
    chk("R11", {name, " err flag"}, 32'(probe_err), 32'(e_err != 0));
    chk("R2", {name, " pending bus ops"}, 32'(ex_k.size()), 32'd0);
    rd(0, v); chk(stag, {name, " status"}, v, 32'(e_err * 16 + e_width));
    rd(1, v); chk("R5", {name, " command set"}, v, 32'(e_vend));
    rd(2, v); chk("R6", {name, " size"}, v, 32'(e_size));
    rd(3, v); chk("R5", {name, " interface"}, v, 32'(e_if));
    rd(4, v); chk("R8", {name, " erase/write exps"}, v, 32'((wm << 24) | (wt << 16) | (em << 8) | et));
    rd(5, v); chk("R9", {name, " buffered exps"}, v, 32'((bm << 8) | bt));
    rd(6, v); chk("R10", {name, " region count"}, v, 32'(e_nreg));
    rd(7, v); chk("R10", {name, " unused index"}, v, 32'd0);
    for (int r = 0; r < NR; r++) begin
      rd(8 + 2 * r, v); chk("R10", {name, " region blocks"}, v, 32'(e_blk[r]));
      rd(9 + 2 * r, v); chk("R10", {name, " region size"}, v, 32'(e_bsz[r]));
    end
  endtask

  initial begin
    logic [31:0] v;
    base_table();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R11", "reset busy", 32'(probe_busy), 32'd0);
    chk("R11", "reset done", 32'(probe_done), 32'd0);
    chk("R2", "reset strobes", 32'(fl_we | fl_re), 32'd0);
    for (int i = 0; i < 16; i++) begin
      rd(i, v); chk("R1", "reset register", v, 32'd0);
    end

    // R1 R5 R6 R8 R9 R10: half-word device, all defaults
    base_table();
    run_case("hw_defaults", 2, "R1");

    // R1 R6 R8 R9 R10: byte device, boundary sums, oversize, count above capacity
    base_table();
    qtab[19] = 8'h03; qtab[39] = 8'd40; qtab[40] = 8'h00;
    qtab[8'h21] = 8'd10; qtab[8'h25] = 8'd31;
    qtab[8'h1F] = 8'd40; qtab[8'h23] = 8'd11;
    qtab[8'h2C] = 8'd6;
    qtab[8'h35] = 8'hFF; qtab[8'h36] = 8'hFF; qtab[8'h37] = 8'h01;
    qtab[8'h3B] = 8'hFF; qtab[8'h3C] = 8'hFF;
    run_case("byte_bounds", 1, "R1");

    // R1: word device
    base_table();
    qtab[19] = 8'h01; qtab[40] = 8'h03;
    run_case("word_dev", 4, "R1");

    // R3: no width answers
    base_table();
    run_case("absent", 8, "R3");

    // R4: bad third signature byte, then bad second
    base_table(); qtab[18] = 8'h58;
    run_case("bad_y", 2, "R4");
    base_table(); qtab[17] = 8'h00;
    run_case("bad_r", 2, "R4");

    // R7: interface word cannot drive a half-word bus
    base_table(); qtab[40] = 8'h00;
    run_case("bad_iface", 2, "R7");

    // R8: typical 42 rejected; default multiplier pushes sum to 42
    base_table(); qtab[40] = 8'h00; qtab[8'h21] = 8'd42;
    run_case("erase_typ", 1, "R8");
    base_table(); qtab[8'h21] = 8'd38;
    run_case("erase_sum", 2, "R8");

    // R9: typical 52 rejected; sum 52 rejected
    base_table(); qtab[8'h1F] = 8'd52;
    run_case("write_typ", 2, "R9");
    base_table(); qtab[8'h1F] = 8'd48; qtab[8'h23] = 8'd4;
    run_case("write_sum", 2, "R9");

    // R10: zero regions
    base_table(); qtab[8'h2C] = 8'd0;
    run_case("no_regions", 2, "R10");

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule